// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Event Codes

The block collects a set of level-sensitive external interrupt lines, one non-maskable line and one debug line. In the same cycle it picks the single winning request and presents it to the CPU, along with that winner's event code. External lines each carry a 4-bit priority that software writes through a small write-only register port. The non-maskable and debug lines have fixed ranks: debug outranks non-maskable, and non-maskable outranks every external level.

Each source has a fixed 8-bit code. The code is driven already shifted left by five bits, so it can serve as a handler branch offset. When the CPU pulses its acknowledge strobe for a non-debug winner, the block captures the presented code into an event register. A debug win is flagged on its own output and carries no code. Acknowledging a debug win leaves the event register unchanged.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, every external priority is 0 and the event register reads 0. With only external lines active, the irq output stays low.
- R2: An external line whose priority is 0 never wins, whatever its request level.
- R3: Among active external lines with nonzero priority, the one with the largest priority value wins. Priority 15 is the highest.
- R4: When several active external lines share the highest priority, the line with the lowest index wins.
- R5: An active non-maskable line wins over every external line, at any priority. Its code is 8'h0E.
- R6: An active debug line wins over all other sources. When it wins, the debug output is high, the irq output is high and the presented code is 0.
- R7: The presented code is the winner's 8-bit code followed by five zero bits. External line i has code 8'h40+i. With no winner, the code is 0 and irq is low.
- R8: If the acknowledge input is high at a rising clock edge while a non-debug winner is presented, the event register takes the presented code at that edge.
- R9: An acknowledge at an edge where the winner is debug, or where there is no winner, leaves the event register at its previous value.
- R10: A write with the write-enable high at a rising edge sets the priority of the addressed external line to the write data. Other lines keep their priorities.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prio_we_i | input | 1 | Priority write enable |
| prio_addr_i | input | 3 | External line index to write |
| prio_wdata_i | input | 4 | New priority value |
| ext_req_i | input | 8 | External level-sensitive requests |
| nmi_i | input | 1 | Non-maskable request |
| dbg_i | input | 1 | Debug request |
| ack_i | input | 1 | CPU interrupt acknowledge strobe |
| irq_o | output | 1 | A winner is presented |
| dbg_o | output | 1 | The winner is the debug request |
| code_o | output | 13 | Shifted code of the winner |
| evt_o | output | 13 | Event register |

## Verification
The bench targets equal-priority ties. A design that compared with greater-or-equal would hand a tie to the highest index instead of the lowest. It also checks that priority 0 masks a line and that reset leaves all lines masked: a design that treated level 0 as a valid low level would raise irq on a bare external request. Acknowledges are issued while debug is active, and while nothing is pending, to catch a design that overwrites the event register with 0 or with a stale code. Random stimulus mixes in priority writes while requests are active, which exposes writes landing on the wrong line and codes shifted by the wrong amount.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned CODE_W    = 8;
  localparam int unsigned EVT_SHIFT = 5;
  localparam int unsigned EVT_W     = CODE_W + EVT_SHIFT;
  localparam logic [CODE_W-1:0] NMI_CODE      = 8'h0E;
  localparam logic [CODE_W-1:0] EXT_CODE_BASE = 8'h40;

  function automatic logic [EVT_W-1:0] shift_code(input logic [CODE_W-1:0] c);
    return {c, {EVT_SHIFT{1'b0}}};
  endfunction
endpackage

// File: rtl/prio_regs.sv
module prio_regs #(
  parameter int unsigned N_EXT  = 8,
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned ADDR_W = (N_EXT > 1) ? $clog2(N_EXT) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [PRIO_W-1:0]             wdata_i,
  output logic [N_EXT-1:0][PRIO_W-1:0]  prio_o
);
  for (genvar g = 0; g < N_EXT; g++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 prio_o[g] <= '0;
      else if (we_i && (addr_i == ADDR_W'(g)))     prio_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/prio_arbiter.sv
module prio_arbiter
  import irq_prio_pkg::*;
#(
  parameter int unsigned N_EXT  = 8,
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned IDX_W = (N_EXT > 1) ? $clog2(N_EXT) : 1
) (
  input  logic [N_EXT-1:0]              req_i,
  input  logic [N_EXT-1:0][PRIO_W-1:0]  prio_i,
  input  logic                          nmi_i,
  input  logic                          dbg_i,
  output logic                          valid_o,
  output logic                          is_dbg_o,
  output logic [EVT_W-1:0]              code_o
);
  logic [PRIO_W-1:0] best_p;
  logic [IDX_W-1:0]  best_i;
  logic              ext_hit;

  // strict compare: ties keep the lower index, level 0 never wins
  always_comb begin
    best_p  = '0;
    best_i  = '0;
    ext_hit = 1'b0;
    for (int i = 0; i < N_EXT; i++) begin
      if (req_i[i] && (prio_i[i] > best_p)) begin
        best_p  = prio_i[i];
        best_i  = IDX_W'(i);
        ext_hit = 1'b1;
      end
    end
  end

  always_comb begin
    valid_o  = dbg_i | nmi_i | ext_hit;
    is_dbg_o = dbg_i;
    if (dbg_i)        code_o = '0;
    else if (nmi_i)   code_o = shift_code(NMI_CODE);
    else if (ext_hit) code_o = shift_code(EXT_CODE_BASE + CODE_W'(best_i));
    else              code_o = '0;
  end
endmodule

// File: rtl/evt_reg.sv
module evt_reg
  import irq_prio_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [EVT_W-1:0] code_i,
  output logic [EVT_W-1:0] evt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     evt_o <= '0;
    else if (load_i) evt_o <= code_i;
  end

  // R7
  evt_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o[EVT_SHIFT-1:0] == '0);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int unsigned N_EXT  = 8,
  parameter int unsigned PRIO_W = 4,
  localparam int unsigned ADDR_W = (N_EXT > 1) ? $clog2(N_EXT) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prio_we_i,
  input  logic [ADDR_W-1:0] prio_addr_i,
  input  logic [PRIO_W-1:0] prio_wdata_i,
  input  logic [N_EXT-1:0]  ext_req_i,
  input  logic              nmi_i,
  input  logic              dbg_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic              dbg_o,
  output logic [EVT_W-1:0]  code_o,
  output logic [EVT_W-1:0]  evt_o
);
  logic [N_EXT-1:0][PRIO_W-1:0] prio;

  prio_regs #(.N_EXT(N_EXT), .PRIO_W(PRIO_W)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (prio_we_i),
    .addr_i  (prio_addr_i),
    .wdata_i (prio_wdata_i),
    .prio_o  (prio)
  );

  prio_arbiter #(.N_EXT(N_EXT), .PRIO_W(PRIO_W)) i_arb (
    .req_i    (ext_req_i),
    .prio_i   (prio),
    .nmi_i    (nmi_i),
    .dbg_i    (dbg_i),
    .valid_o  (irq_o),
    .is_dbg_o (dbg_o),
    .code_o   (code_o)
  );

  evt_reg i_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ack_i & irq_o & ~dbg_o),
    .code_i (code_o),
    .evt_o  (evt_o)
  );

  // R5
  nmi_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_i && !dbg_i) |-> (irq_o && !dbg_o && code_o == shift_code(NMI_CODE)));
  // R6
  dbg_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_i |-> (irq_o && dbg_o && code_o == '0));
  // R7
  idle_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (code_o == '0));
  // R8
  evt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !dbg_o) |=> (evt_o == $past(code_o)));
  // R9
  evt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && (dbg_o || !irq_o)) |=> $stable(evt_o));
  // R2
  mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !nmi_i && !dbg_i) |-> ((ext_req_i & ~N_EXT'(0)) != '0));
endmodule

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [3:0]  wdata = '0;
  logic [N-1:0] req = '0;
  logic        nmi = 1'b0, dbg = 1'b0, ack = 1'b0;
  logic        irq, dbgo;
  logic [12:0] code, evt;

  int compared = 0, mismatched = 0;
  int m_prio[N];
  int m_evt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .prio_we_i(we), .prio_addr_i(addr),
    .prio_wdata_i(wdata), .ext_req_i(req), .nmi_i(nmi), .dbg_i(dbg),
    .ack_i(ack), .irq_o(irq), .dbg_o(dbgo), .code_o(code), .evt_o(evt)
  );

  task automatic chk(string r, int got, int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", r, got, exp, $time);
    end
  endtask

  // model: scan levels from top down, indices from low up
  task automatic expect_now(output int e_irq, output int e_dbg, output int e_code,
                            output string tag);
    e_irq = 0; e_dbg = 0; e_code = 0; tag = "R7";
    if (dbg) begin e_irq = 1; e_dbg = 1; tag = "R6"; return; end
    if (nmi) begin e_irq = 1; e_code = 'h0E * 32; tag = "R5"; return; end
    for (int lvl = 15; lvl >= 1; lvl--)
      for (int i = 0; i < N; i++)
        if (req[i] && m_prio[i] == lvl) begin
          e_irq = 1; e_code = ('h40 + i) * 32; tag = "R3_R4"; return;
        end
  endtask

  // one cycle: inputs set at negedge, compare, then apply edge to model
  task automatic step(logic w, int a, int d, logic [N-1:0] rq, logic n,
                      logic g, logic k, string hint);
    int e_irq, e_dbg, e_code;
    string tag;
    @(negedge clk);
    chk("R8_R9 evt", int'(evt), m_evt);
    we = w; addr = 3'(a); wdata = 4'(d); req = rq; nmi = n; dbg = g; ack = k;
    #1;
    expect_now(e_irq, e_dbg, e_code, tag);
    chk({tag, " irq ", hint}, int'(irq), e_irq);
    chk({tag, " dbg ", hint}, int'(dbgo), e_dbg);
    chk({tag, " code ", hint}, int'(code), e_code);
    @(posedge clk);
    if (k && e_irq && !e_dbg) m_evt = e_code;
    if (w) m_prio[a] = d;
  endtask

  initial begin
    for (int i = 0; i < N; i++) m_prio[i] = 0;
    #12 rst_n = 1'b1;
    // R1: reset state, all lines masked
    step(0, 0, 0, '1, 0, 0, 1, "R1");
    chk("R1 evt", int'(evt), 0);
    // R10 writes, R2 masked line stays out
    step(1, 3, 7, '0, 0, 0, 0, "R10");
    step(1, 5, 7, '0, 0, 0, 0, "R10");
    step(0, 0, 0, 8'b0000_0001, 0, 0, 0, "R2");
    step(0, 0, 0, 8'b0010_1000, 0, 0, 1, "R4 tie");   // line 3 wins
    step(1, 6, 15, 8'b0110_1000, 0, 0, 0, "R3");
    step(0, 0, 0, 8'b0110_1000, 0, 0, 1, "R3 top");   // line 6 wins
    step(0, 0, 0, 8'b0110_1000, 1, 0, 1, "R5");
    step(0, 0, 0, 8'b0110_1000, 1, 1, 1, "R6 R9");
    step(0, 0, 0, '0, 0, 0, 1, "R9 idle");
    step(1, 6, 0, 8'b0100_0000, 0, 0, 1, "R10");
    step(0, 0, 0, 8'b0100_0000, 0, 0, 1, "R2 rewritten");
    step(1, 7, 15, 8'b1000_0000, 0, 0, 0, "R10");
    step(0, 0, 0, 8'b1000_0000, 0, 0, 1, "R7 top line");
    for (int c = 0; c < 3000; c++) begin
      int r = $urandom_range(0, 99);
      step(r < 15, $urandom_range(0, N - 1), $urandom_range(0, 15),
           N'($urandom), r > 93, r > 96, $urandom_range(0, 2) == 0, "rand");
    end
    @(negedge clk);
    chk("R8_R9 evt", int'(evt), m_evt);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #200000;
        mismatched++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule